// File: doc/BRIEF.md
# Four-Lane Fractional-Delay FIR Filter

This block delays a sampled stream by a fraction of a sample period. The stream arrives as one 32-bit word per clock. Each word carries four signed 8-bit samples, so every clock four new samples enter and four filtered samples leave. A 10-tap FIR filter performs the interpolation. The filter is unrolled four ways into a pipelined chain of tap stages. Stage k adds its products into the four running partial sums. It takes its samples from the delayed input words, rotated by k lanes, so that every partial sum meets the sample lying k positions behind its own output sample.

Ten coefficient sets are held in a stored table. Index 0 is the integer setting, which has a single unit tap. Indices 1 to 9 stand for delays of 0.1 to 0.9 sample. The table is loaded with unit-tap sets at reset and can be rewritten one coefficient at a time through a write port. Only the active bank drives the filter. A swap strobe copies one stored set into that bank. The new set takes effect on a word boundary, and every word is filtered with a single set from start to end. Whole-sample delays are applied upstream of this block.

Top module: `frac_delay_fir4`

## Requirements
- R1: Lane j of `din` and `dout` is bits [8j+7:8j] and holds two's-complement samples. Lane 0 is the earliest sample of its word. Output sample n is y(n) = sum over k=0..9 of h[k]·x(n−k). Samples before the first word after reset count as zero.
- R2: The output word for the input word captured at clock edge m appears on `dout` after edge m+11.
- R3: Reset clears the sample pipeline and `dout` to zero. It loads every stored set and the active bank with 16384 at tap 4 and zero at every other tap, so that after reset the block delays its input by exactly 4 samples.
- R4: Coefficients are signed 16-bit values with 14 fraction bits. Products are summed at full width. The sum is rounded by adding 8192 and shifting right arithmetically by 14, then saturated to the range −128..127.
- R5: A write with `cw_en` high stores `cw_data` at set `cw_set`, tap `cw_tap`. It leaves the active bank, and so `dout`, unchanged until a swap occurs.
- R6: When `swap_en` is high with `swap_set` below 10, stored set `swap_set` becomes active. The word presented in the same cycle and all later words use the new set. Earlier words finish with the old set, and no word mixes the two sets.
- R7: A swap with `swap_set` of 10 or more, or a write with `cw_set` or `cw_tap` of 10 or more, changes neither the table nor the active bank.
- R8: After 15 consecutive all-zero input words, `dout` is zero.
- R9: After the active bank has held all-zero coefficients for 11 consecutive cycles, `dout` is zero.
- R10: If a write and a swap address the same set in the same cycle, the swap loads the contents that set held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Four input samples, lane 0 earliest |
| swap_en | input | 1 | Swap strobe: copy a stored set into the active bank |
| swap_set | input | 4 | Index of the stored set to activate |
| cw_en | input | 1 | Coefficient write strobe |
| cw_set | input | 4 | Set index of the coefficient write |
| cw_tap | input | 4 | Tap index of the coefficient write |
| cw_data | input | 16 | Signed coefficient value to write |
| dout | output | 32 | Four filtered samples, lane 0 earliest |

## Verification
Faults in this block show up as wrong samples at `dout`, and they show up soon.
- A wrong lane rotation or a wrong delay-line depth makes an impulse appear in the wrong lane or the wrong word. This is visible 11 cycles after the input.
- A coefficient pipe that is too short makes the word in flight during a swap come out with a blend of two sets. Only the words at the swap boundary are affected, so the bench compares every word on every clock, with a swap placed in the middle of live data.
- Rounding and saturation faults show up as errors of one code, or as wrapped values, on small odd inputs and on full-scale inputs.

// File: rtl/frac_delay_fir4.sv
module frac_delay_fir4 #(
  parameter int LANES    = 4,
  parameter int SW       = 8,
  parameter int TAPS     = 10,
  parameter int CW       = 16,
  parameter int FRAC     = 14,
  parameter int NSETS    = 10,
  parameter int UNIT_TAP = 4,
  localparam int SELW    = $clog2(NSETS + 1),
  localparam int TAPW    = $clog2(TAPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*SW-1:0]   din,
  input  logic                  swap_en,
  input  logic [SELW-1:0]       swap_set,
  input  logic                  cw_en,
  input  logic [SELW-1:0]       cw_set,
  input  logic [TAPW-1:0]       cw_tap,
  input  logic [CW-1:0]         cw_data,
  output logic [LANES*SW-1:0]   dout
);
  localparam int WW   = LANES * SW;
  localparam int QMAX = (TAPS - 1 + LANES - 1) / LANES;
  localparam int DL   = TAPS + QMAX;
  localparam int AW   = SW + CW + $clog2(TAPS);
  localparam int LAT  = TAPS + 1;
  localparam logic signed [CW-1:0] UNIT = CW'(1) << FRAC;
  localparam logic [TAPS*CW-1:0] RST_ACT = (TAPS*CW)'(UNIT) << (UNIT_TAP * CW);
  localparam logic signed [AW:0] HALF = (AW+1)'(1) << (FRAC - 1);
  localparam logic signed [AW:0] MAXV = (AW+1)'(2**(SW-1) - 1);
  localparam logic signed [AW:0] MINV = ~MAXV;
  localparam logic [SELW-1:0] NSETS_L = SELW'(NSETS);
  localparam logic [TAPW-1:0] TAPS_L  = TAPW'(TAPS);

  logic signed [CW-1:0]      tbl [NSETS][TAPS];
  logic [TAPS*CW-1:0]        act;
  logic [WW-1:0]             dl [DL];
  logic signed [CW-1:0]      ck [TAPS];
  logic signed [SW+CW-1:0]   prod [TAPS][LANES];
  logic signed [AW-1:0]      ps [TAPS][LANES];
  logic [WW-1:0]             res;

  wire sw_ok = swap_en && (swap_set < NSETS_L);
  wire wr_ok = cw_en && (cw_set < NSETS_L) && (cw_tap < TAPS_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++)
        for (int t = 0; t < TAPS; t++)
          tbl[s][t] <= (t == UNIT_TAP) ? UNIT : '0;
      act <= RST_ACT;
    end else begin
      if (sw_ok)
        for (int t = 0; t < TAPS; t++)
          act[t*CW +: CW] <= tbl[swap_set][t];
      if (wr_ok)
        tbl[cw_set][cw_tap] <= cw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < DL; d++) dl[d] <= '0;
    end else begin
      dl[0] <= din;
      for (int d = 1; d < DL; d++) dl[d] <= dl[d-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    if (k == 0) begin : g_now
      assign ck[k] = act[k*CW +: CW];
    end else begin : g_pipe
      logic signed [CW-1:0] pipe [k];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int d = 0; d < k; d++) pipe[d] <= RST_ACT[k*CW +: CW];
        end else begin
          pipe[0] <= act[k*CW +: CW];
          for (int d = 1; d < k; d++) pipe[d] <= pipe[d-1];
        end
      end
      assign ck[k] = pipe[k-1];
    end
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam int Q   = (k - j + LANES - 1) / LANES;
      localparam int SRC = j - k + LANES * Q;
      wire signed [SW-1:0] xs = dl[k+Q][SRC*SW +: SW];
      assign prod[k][j] = xs * ck[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++)
        for (int j = 0; j < LANES; j++) ps[k][j] <= '0;
    end else begin
      for (int j = 0; j < LANES; j++) ps[0][j] <= AW'(prod[0][j]);
      for (int k = 1; k < TAPS; k++)
        for (int j = 0; j < LANES; j++)
          ps[k][j] <= ps[k-1][j] + AW'(prod[k][j]);
    end
  end

  function automatic logic [SW-1:0] rnd_sat(input logic signed [AW-1:0] a);
    logic signed [AW:0] r;
    r = (AW+1)'(a);
    r = r + HALF;
    r = r >>> FRAC;
    if (r > MAXV)      return MAXV[SW-1:0];
    else if (r < MINV) return MINV[SW-1:0];
    else               return r[SW-1:0];
  endfunction

  always_comb
    for (int j = 0; j < LANES; j++) res[j*SW +: SW] = rnd_sat(ps[TAPS-1][j]);

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else        dout <= res;
  end

  localparam int ZIN_WIN = LAT + QMAX + 1;
  localparam int ZW      = $clog2(ZIN_WIN + 1);
  logic [ZW-1:0] zi, zc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zi <= '0;
      zc <= '0;
    end else begin
      if (din != '0)                zi <= '0;
      else if (zi != ZW'(ZIN_WIN))  zi <= zi + ZW'(1);
      if (act != '0)                zc <= '0;
      else if (zc != ZW'(ZIN_WIN))  zc <= zc + ZW'(1);
    end
  end

  p_zero_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zi == ZW'(ZIN_WIN)) |-> (dout == '0));

  p_zero_coef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zc >= ZW'(LAT)) |-> (dout == '0));

  p_hold_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_en |=> $stable(act));

  p_bad_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && swap_set >= NSETS_L) |=> $stable(act));
endmodule

// File: tb/test_frac_delay_fir4.sv
module test_frac_delay_fir4;
  localparam int NW = 1024;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [31:0] din;
  logic        swap_en;
  logic [3:0]  swap_set;
  logic        cw_en;
  logic [3:0]  cw_set;
  logic [3:0]  cw_tap;
  logic [15:0] cw_data;
  logic [31:0] dout;

  frac_delay_fir4 i_frac_delay_fir4 (
    .clk(clk), .rst_n(rst_n), .din(din), .swap_en(swap_en), .swap_set(swap_set),
    .cw_en(cw_en), .cw_set(cw_set), .cw_tap(cw_tap), .cw_data(cw_data), .dout(dout)
  );

  int total = 0;
  int bad = 0;
  int e = 0;
  string cur = "R3";
  logic [31:0] words [NW];
  int cfw [NW][10];
  int tm [10][10];
  int am [10];

  function automatic int sample(int n);
    if (n < 0) return 0;
    return $signed(words[n/4][8*(n%4) +: 8]);
  endfunction

  function automatic logic [31:0] expect_word(int w);
    logic [31:0] res = '0;
    if (w < 0) return '0;
    for (int j = 0; j < 4; j++) begin
      int acc = 0;
      int r;
      for (int k = 0; k < 10; k++) acc += cfw[w][k] * sample(4*w + j - k);
      r = (acc + 8192) >>> 14;
      if (r > 127) r = 127;
      if (r < -128) r = -128;
      res[8*j +: 8] = r[7:0];
    end
    return res;
  endfunction

  task automatic step(input logic [31:0] w, input logic sw, input logic [3:0] ss,
                      input logic we, input logic [3:0] ws, input logic [3:0] wt,
                      input logic [15:0] wd);
    logic [31:0] exp;
    din = w; swap_en = sw; swap_set = ss;
    cw_en = we; cw_set = ws; cw_tap = wt; cw_data = wd;
    @(posedge clk);
    if (sw && ss < 10) for (int t = 0; t < 10; t++) am[t] = tm[ss][t];
    if (we && ws < 10 && wt < 10) tm[ws][wt] = $signed(wd);
    words[e] = w;
    for (int t = 0; t < 10; t++) cfw[e][t] = am[t];
    e++;
    @(negedge clk);
    exp = expect_word(e - 12);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s word %0d: actual=%h expected=%h", cur, e - 12, dout, exp);
    end
  endtask

  task automatic data(input logic [31:0] w);
    step(w, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 16'd0);
  endtask

  task automatic wr(input int s, input int t, input int v);
    step($urandom, 1'b0, 4'd0, 1'b1, 4'(s), 4'(t), 16'(v));
  endtask

  task automatic swp(input int s);
    step($urandom, 1'b1, 4'(s), 1'b0, 4'd0, 4'd0, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c1 [10] = '{-300, 700, -1500, 3200, 13000, 5200, -2100, 900, -400, 150};
    for (int s = 0; s < 10; s++)
      for (int t = 0; t < 10; t++) tm[s][t] = (t == 4) ? 16384 : 0;
    for (int t = 0; t < 10; t++) am[t] = (t == 4) ? 16384 : 0;
    rst_n = 1'b0; din = '0; swap_en = 0; swap_set = '0;
    cw_en = 0; cw_set = '0; cw_tap = '0; cw_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (dout !== '0) begin
      bad++;
      $display("FAIL R3 reset: actual=%h expected=00000000", dout);
    end
    rst_n = 1'b1;

    cur = "R3";
    for (int i = 0; i < 20; i++) data($urandom);
    cur = "R2";
    data(32'h0000_0040);
    for (int i = 0; i < 14; i++) data('0);
    data(32'h5A00_0000);
    for (int i = 0; i < 14; i++) data('0);
    cur = "R1";
    for (int i = 0; i < 30; i++) data($urandom);

    cur = "R5";
    for (int t = 0; t < 10; t++) wr(1, t, c1[t]);
    for (int i = 0; i < 15; i++) data($urandom);

    cur = "R6";
    for (int i = 0; i < 5; i++) data($urandom);
    swp(1);
    for (int i = 0; i < 30; i++) data($urandom);
    swp(0);
    swp(1);
    for (int i = 0; i < 20; i++) data($urandom);

    cur = "R4";
    wr(2, 4, 0);
    wr(2, 0, 8192);
    swp(2);
    for (int i = 0; i < 4; i++) data(32'hFD03_FF01);
    data(32'h0503_0101);
    data(32'hFBFD_FFFF);
    for (int i = 0; i < 12; i++) data($urandom);
    for (int t = 0; t < 10; t++) wr(3, t, 32767);
    swp(3);
    for (int i = 0; i < 6; i++) data(32'h7F7F_7F7F);
    for (int i = 0; i < 6; i++) data(32'h8080_8080);
    for (int i = 0; i < 6; i++) data(32'h7F80_7F80);
    for (int i = 0; i < 12; i++) data($urandom);

    cur = "R7";
    swp(1);
    for (int i = 0; i < 12; i++) data($urandom);
    swp(12);
    for (int i = 0; i < 14; i++) data($urandom);
    wr(11, 2, 12345);
    wr(1, 13, 12345);
    swp(15);
    swp(1);
    for (int i = 0; i < 14; i++) data($urandom);

    cur = "R10";
    step($urandom, 1'b1, 4'd2, 1'b1, 4'd2, 4'd0, 16'd16384);
    for (int i = 0; i < 14; i++) data($urandom);
    swp(2);
    for (int i = 0; i < 14; i++) data($urandom);

    cur = "R8";
    for (int i = 0; i < 20; i++) data('0);

    cur = "R9";
    wr(4, 4, 0);
    swp(4);
    for (int i = 0; i < 20; i++) data($urandom);
    swp(0);
    for (int i = 0; i < 14; i++) data($urandom);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule